// File: doc/BRIEF.md
# Multi-Queue Interrupt Source Controller

This block raises the interrupt requests for a 64-queue hardware queue manager. The queues form a low half (0..31) and a high half (32..63). Each half has its own enable register, its own sticky status register that software clears by writing ones, and its own interrupt line. Each low-half queue has a small source field. The field picks which of that queue's four status flags raises an interrupt, and it can invert the chosen flag. Each high-half queue always uses its "not nearly empty" flag.

The queue storage logic supplies the status flags every cycle. A status bit is captured on a rising edge of the queue's selected condition, and only while that queue is enabled. Software reaches the block through a simple word-addressed register bus with a single write strobe and combinational read data. For each half, the block also gives the number of the highest pending enabled queue, so software can service queues from the top index downward without scanning.

Top module: `qirq_ctrl`

## Requirements
- R1: After reset, every register reads 0, and both interrupt lines are low.
- R2: Each low queue has four flag inputs at lo_flags[4q+k]. Source field bits [1:0] give k: 0 empty, 1 nearly empty, 2 nearly full, 3 full.
- R3: When source field bit 2 is 1, the selected flag is inverted before edge detection.
- R4: Source field bit 3 is reserved. It is not stored, it reads as 0, and it has no effect on the condition.
- R5: The source field of low queue q sits in source register q/8 (addresses 0..3), at bits (q mod 8)*4+3 .. (q mod 8)*4.
- R6: The condition for high queue q (32..63) is always input hi_avail[q-32], with no way to configure it.
- R7: A status bit goes to 1 only in the cycle after a 0-to-1 change of its queue's condition, and only if the queue's enable bit was 1. A condition held high sets nothing more.
- R8: Writing to a status register (address 6 low, 7 high) clears each bit written as 1. Bits written as 0 keep their value.
- R9: If a condition edge on an enabled queue and a clearing write hit the same status bit in the same cycle, the bit ends at 1.
- R10: Each interrupt line is high exactly when some bit of its half has both status and enable at 1. A status bit whose enable is 0 stays readable but does not drive the line.
- R11: Address 8 (low) and address 9 (high) read bit 31 as "some enabled queue pending" and bits [4:0] as the highest such queue index within the half. All other bits read 0.
- R12: The register map is: 0..3 source, 4 enable low, 5 enable high, 6 status low, 7 status high, 8 and 9 top-pending (read only). Other addresses read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| lo_flags | input | 128 | Four status flags per low queue |
| hi_avail | input | 32 | Not-nearly-empty flag per high queue |
| irq_lo | output | 1 | Interrupt line of the low half |
| irq_hi | output | 1 | Interrupt line of the high half |

## Verification
The hardest state to reach from the ports is a rising condition edge on an enabled queue that lands in the same cycle as a clearing write to the same bit. The stimulus first drops the queue's flag, then raises it in the very cycle the write strobe carries a one for that bit. A second hard case is a condition edge caused only by a change in configuration: rewriting a source field with the inversion bit, or with a different flag selected, can create a rising edge even while the flag inputs stay still. The bench reaches this by reprogramming source registers during long random runs. Its behavioural model tracks the previous condition of every queue, so it predicts these edges.

// File: rtl/qirq_pkg.sv
package qirq_pkg;

    localparam int NQ_HALF     = 32;
    localparam int FLAG_W      = 4;
    localparam int SRC_W       = 4;
    localparam int DW          = 32;
    localparam int AW          = 4;
    localparam int SRC_PER_REG = DW / SRC_W;
    localparam int NSRC_REG    = NQ_HALF / SRC_PER_REG;
    localparam int IDX_W       = $clog2(NQ_HALF);

    localparam logic [AW-1:0] RA_SRC0   = 4'd0;
    localparam logic [AW-1:0] RA_EN_LO  = 4'd4;
    localparam logic [AW-1:0] RA_ST_LO  = 4'd6;
    localparam logic [AW-1:0] RA_TOP_LO = 4'd8;

    typedef enum logic [1:0] {
        FLG_EMPTY       = 2'd0,
        FLG_NEAR_EMPTY  = 2'd1,
        FLG_NEAR_FULL   = 2'd2,
        FLG_FULL        = 2'd3
    } flag_sel_e;

    typedef struct packed {
        logic      rsvd;
        logic      inv;
        flag_sel_e sel;
    } src_fld_t;

    // selected flag of one queue, optionally inverted
    function automatic logic pick_cond(src_fld_t f, logic [FLAG_W-1:0] flags);
        return flags[f.sel] ^ f.inv;
    endfunction

    // reserved bit of every packed field is never stored
    function automatic logic [DW-1:0] strip_rsvd(logic [DW-1:0] v);
        logic [DW-1:0] r;
        r = v;
        for (int i = 0; i < SRC_PER_REG; i++) begin
            r[i*SRC_W + SRC_W - 1] = 1'b0;
        end
        return r;
    endfunction

endpackage

// File: rtl/qirq_src_bank.sv
module qirq_src_bank
    import qirq_pkg::*;
#(
    parameter int NQ = NQ_HALF,
    parameter int FW = FLAG_W,
    parameter int W  = DW,
    localparam int NREG = NQ / (W / SRC_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NREG-1:0]   wr_sel,
    input  logic [W-1:0]      wdata,
    input  logic [NQ*FW-1:0]  flags,
    output logic [NQ-1:0]     cond,
    output logic [NREG*W-1:0] regs_o
);

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        logic [W-1:0] reg_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                reg_q <= '0;
            end else if (wr_sel[r]) begin
                reg_q <= strip_rsvd(wdata);
            end
        end
        assign regs_o[r*W +: W] = reg_q;
    end

    // field of queue q lands at flat offset q*SRC_W
    for (genvar q = 0; q < NQ; q++) begin : g_cond
        src_fld_t fld;
        assign fld     = src_fld_t'(regs_o[q*SRC_W +: SRC_W]);
        assign cond[q] = pick_cond(fld, flags[q*FW +: FW]);
    end

endmodule

// File: rtl/qirq_half.sv
module qirq_half #(
    parameter int NQ = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NQ-1:0] cond,
    input  logic          en_we,
    input  logic          st_we,
    input  logic [NQ-1:0] wdata,
    output logic [NQ-1:0] en_o,
    output logic [NQ-1:0] stat_o,
    output logic [NQ-1:0] rise_o,
    output logic          irq
);

    logic [NQ-1:0] prev_q;
    logic [NQ-1:0] en_q;
    logic [NQ-1:0] st_q;
    logic [NQ-1:0] set_v;
    logic [NQ-1:0] clr_v;

    assign rise_o = cond & ~prev_q;
    assign set_v  = rise_o & en_q;
    assign clr_v  = st_we ? wdata : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            en_q   <= '0;
            st_q   <= '0;
        end else begin
            prev_q <= cond;
            st_q   <= (st_q & ~clr_v) | set_v;
            if (en_we) begin
                en_q <= wdata;
            end
        end
    end

    assign en_o   = en_q;
    assign stat_o = st_q;
    assign irq    = |(st_q & en_q);

endmodule

// File: rtl/qirq_top_find.sv
module qirq_top_find #(
    parameter int NQ = 32,
    localparam int IW = $clog2(NQ)
) (
    input  logic [NQ-1:0] pend,
    output logic          vld,
    output logic [IW-1:0] idx
);

    always_comb begin
        vld = 1'b0;
        idx = '0;
        for (int i = 0; i < NQ; i++) begin
            if (pend[i]) begin
                vld = 1'b1;
                idx = IW'(i);
            end
        end
    end

endmodule

// File: rtl/qirq_ctrl.sv
module qirq_ctrl
    import qirq_pkg::*;
#(
    parameter int NQ = NQ_HALF,
    parameter int W  = DW,
    parameter int A  = AW,
    localparam int NREG = NQ / (W / SRC_W),
    localparam int IW   = $clog2(NQ)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_we,
    input  logic [A-1:0]        bus_addr,
    input  logic [W-1:0]        bus_wdata,
    output logic [W-1:0]        bus_rdata,
    input  logic [NQ*FLAG_W-1:0] lo_flags,
    input  logic [NQ-1:0]       hi_avail,
    output logic                irq_lo,
    output logic                irq_hi
);

    logic [NREG-1:0]   src_sel;
    logic [NREG*W-1:0] src_regs;
    logic [NQ-1:0]     cond_v  [2];
    logic [NQ-1:0]     en_v    [2];
    logic [NQ-1:0]     stat_v  [2];
    logic [NQ-1:0]     rise_v  [2];
    logic              irq_v   [2];
    logic              top_vld [2];
    logic [IW-1:0]     top_idx [2];

    for (genvar r = 0; r < NREG; r++) begin : g_dec
        assign src_sel[r] = bus_we && (bus_addr == A'(int'(RA_SRC0) + r));
    end

    qirq_src_bank #(.NQ(NQ), .FW(FLAG_W), .W(W)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .wr_sel (src_sel),
        .wdata  (bus_wdata),
        .flags  (lo_flags),
        .cond   (cond_v[0]),
        .regs_o (src_regs)
    );

    assign cond_v[1] = hi_avail;

    for (genvar h = 0; h < 2; h++) begin : g_half
        logic en_we;
        logic st_we;
        assign en_we = bus_we && (bus_addr == A'(int'(RA_EN_LO) + h));
        assign st_we = bus_we && (bus_addr == A'(int'(RA_ST_LO) + h));

        qirq_half #(.NQ(NQ)) u_half (
            .clk    (clk),
            .rst    (rst),
            .cond   (cond_v[h]),
            .en_we  (en_we),
            .st_we  (st_we),
            .wdata  (bus_wdata[NQ-1:0]),
            .en_o   (en_v[h]),
            .stat_o (stat_v[h]),
            .rise_o (rise_v[h]),
            .irq    (irq_v[h])
        );

        qirq_top_find #(.NQ(NQ)) u_find (
            .pend (stat_v[h] & en_v[h]),
            .vld  (top_vld[h]),
            .idx  (top_idx[h])
        );
    end

    assign irq_lo = irq_v[0];
    assign irq_hi = irq_v[1];

    always_comb begin
        bus_rdata = '0;
        for (int r = 0; r < NREG; r++) begin
            if (bus_addr == A'(int'(RA_SRC0) + r)) begin
                bus_rdata = src_regs[r*W +: W];
            end
        end
        for (int h = 0; h < 2; h++) begin
            if (bus_addr == A'(int'(RA_EN_LO) + h)) begin
                bus_rdata = W'(en_v[h]);
            end
            if (bus_addr == A'(int'(RA_ST_LO) + h)) begin
                bus_rdata = W'(stat_v[h]);
            end
            if (bus_addr == A'(int'(RA_TOP_LO) + h)) begin
                bus_rdata          = '0;
                bus_rdata[W-1]     = top_vld[h];
                bus_rdata[IW-1:0]  = top_idx[h];
            end
        end
    end

endmodule

// File: rtl/qirq_ctrl_chk.sv
module qirq_ctrl_chk
    import qirq_pkg::*;
#(
    parameter int NQ = NQ_HALF,
    localparam int IW = $clog2(NQ)
) (
    input logic          clk,
    input logic          rst,
    input logic          we,
    input logic [AW-1:0] addr,
    input logic [DW-1:0] wdata,
    input logic [NQ-1:0] hi_avail,
    input logic [NQ-1:0] stat_lo,
    input logic [NQ-1:0] stat_hi,
    input logic [NQ-1:0] en_lo,
    input logic [NQ-1:0] en_hi,
    input logic [NQ-1:0] rise_lo,
    input logic          irq_lo,
    input logic          irq_hi,
    input logic          top_lo_vld,
    input logic [IW-1:0] top_lo_idx,
    input logic          top_hi_vld,
    input logic [IW-1:0] top_hi_idx
);

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (stat_lo == '0 && stat_hi == '0 && en_lo == '0 && en_hi == '0));

    assert_set_needs_en_R7: assert property (@(posedge clk) disable iff (rst)
        ((stat_lo & ~$past(stat_lo) & ~$past(en_lo)) == '0) &&
        ((stat_hi & ~$past(stat_hi) & ~$past(en_hi)) == '0));

    assert_set_needs_rise_R7: assert property (@(posedge clk) disable iff (rst)
        (stat_lo & ~$past(stat_lo) & ~$past(rise_lo)) == '0);

    assert_hi_fixed_cond_R6: assert property (@(posedge clk) disable iff (rst)
        (stat_hi & ~$past(stat_hi) & ~$past(hi_avail)) == '0);

    assert_w1c_clears_R8: assert property (@(posedge clk) disable iff (rst)
        $past(we && addr == RA_ST_LO) |->
            ((stat_lo & $past(wdata[NQ-1:0]) & ~$past(rise_lo & en_lo)) == '0));

    assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
        $past(we && addr == RA_ST_LO) |->
            ((stat_lo & $past(rise_lo & en_lo)) == $past(rise_lo & en_lo)));

    assert_irq_matches_top_R10: assert property (@(posedge clk) disable iff (rst)
        (irq_lo == top_lo_vld) && (irq_hi == top_hi_vld));

    assert_top_is_highest_R11: assert property (@(posedge clk) disable iff (rst)
        top_lo_vld |-> (((stat_lo & en_lo) >> top_lo_idx) == NQ'(1)));

    assert_top_hi_highest_R11: assert property (@(posedge clk) disable iff (rst)
        top_hi_vld |-> (((stat_hi & en_hi) >> top_hi_idx) == NQ'(1)));

endmodule

bind qirq_ctrl qirq_ctrl_chk #(.NQ(NQ)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .we         (bus_we),
    .addr       (bus_addr),
    .wdata      (bus_wdata),
    .hi_avail   (hi_avail),
    .stat_lo    (stat_v[0]),
    .stat_hi    (stat_v[1]),
    .en_lo      (en_v[0]),
    .en_hi      (en_v[1]),
    .rise_lo    (rise_v[0]),
    .irq_lo     (irq_lo),
    .irq_hi     (irq_hi),
    .top_lo_vld (top_vld[0]),
    .top_lo_idx (top_idx[0]),
    .top_hi_vld (top_vld[1]),
    .top_hi_idx (top_idx[1])
);

// File: tb/qirq_ctrl_tb_top.sv
module qirq_ctrl_tb_top;

    logic         clk = 1'b0;
    logic         rst;
    logic         bus_we;
    logic [3:0]   bus_addr;
    logic [31:0]  bus_wdata;
    logic [31:0]  bus_rdata;
    logic [127:0] lo_flags;
    logic [31:0]  hi_avail;
    logic         irq_lo;
    logic         irq_hi;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // behavioural model state
    logic [3:0]  m_src [32];
    logic [31:0] m_en   [2];
    logic [31:0] m_st   [2];
    logic [31:0] m_prev [2];

    always #5 clk = ~clk;

    qirq_ctrl dut_i (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .lo_flags  (lo_flags),
        .hi_avail  (hi_avail),
        .irq_lo    (irq_lo),
        .irq_hi    (irq_hi)
    );

    function automatic logic [31:0] m_cond(int h);
        logic [31:0] c;
        if (h == 1) return hi_avail;
        for (int q = 0; q < 32; q++) begin
            c[q] = lo_flags[q*4 + int'(m_src[q][1:0])] ^ m_src[q][2];
        end
        return c;
    endfunction

    function automatic logic [31:0] m_read(int a);
        logic [31:0] v;
        logic [31:0] p;
        v = '0;
        if (a < 4) begin
            for (int k = 0; k < 8; k++) v[k*4 +: 4] = m_src[a*8 + k];
        end else if (a == 4 || a == 5) begin
            v = m_en[a-4];
        end else if (a == 6 || a == 7) begin
            v = m_st[a-6];
        end else if (a == 8 || a == 9) begin
            p = m_st[a-8] & m_en[a-8];
            for (int i = 0; i < 32; i++) begin
                if (p[i]) begin
                    v = 32'h8000_0000 | i;
                end
            end
        end
        return v;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock: predict, advance, compare away from the edge
    task automatic cyc();
        logic [31:0] c [2];
        logic [31:0] nst [2];
        logic [31:0] clr;
        for (int h = 0; h < 2; h++) begin
            c[h]   = m_cond(h);
            clr    = (bus_we && bus_addr == 4'(6 + h)) ? bus_wdata : 32'h0;
            nst[h] = (m_st[h] & ~clr) | (c[h] & ~m_prev[h] & m_en[h]);
        end
        @(posedge clk);
        if (rst) begin
            for (int q = 0; q < 32; q++) m_src[q] = 4'h0;
            for (int h = 0; h < 2; h++) begin
                m_en[h] = '0; m_st[h] = '0; m_prev[h] = '0;
            end
        end else begin
            for (int h = 0; h < 2; h++) begin
                m_st[h]   = nst[h];
                m_prev[h] = c[h];
            end
            if (bus_we && bus_addr < 4) begin
                for (int k = 0; k < 8; k++)
                    m_src[int'(bus_addr)*8 + k] = bus_wdata[k*4 +: 4] & 4'h7;
            end
            if (bus_we && bus_addr == 4) m_en[0] = bus_wdata;
            if (bus_we && bus_addr == 5) m_en[1] = bus_wdata;
        end
        @(negedge clk);
        if (!rst) begin
            chk("R10 irq_lo", 32'(irq_lo), 32'(|(m_st[0] & m_en[0])));
            chk("R10 irq_hi", 32'(irq_hi), 32'(|(m_st[1] & m_en[1])));
            chk("R12 rdata", bus_rdata, m_read(int'(bus_addr)));
        end
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        bus_we    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        cyc();
        bus_we    = 1'b0;
    endtask

    task automatic expect_reg(string tag, logic [3:0] a, logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
        lo_flags = '0; hi_avail = '0;
        repeat (3) cyc();
        rst = 1'b0;
        cyc();
        // R1: reset state
        for (int a = 0; a < 10; a++) expect_reg("R1 reg", 4'(a), 32'h0);
        chk("R1 irq", {30'h0, irq_hi, irq_lo}, 32'h0);

        // R2 R5: queue 1 selects nearly-full (reg 0 bits 7:4)
        wr(4'd0, 32'h0000_0020);
        wr(4'd4, 32'h0000_0002);
        lo_flags[1*4 + 2] = 1'b1;
        cyc();
        expect_reg("R2 R5 stat lo", 4'd6, 32'h0000_0002);
        chk("R10 irq_lo set", 32'(irq_lo), 32'h1);
        expect_reg("R11 top lo", 4'd8, 32'h8000_0001);

        // R8: zero write keeps, one write clears
        wr(4'd6, 32'h0);
        expect_reg("R8 zero write", 4'd6, 32'h0000_0002);
        wr(4'd6, 32'h0000_0002);
        expect_reg("R8 one write", 4'd6, 32'h0);
        chk("R8 irq after clear", 32'(irq_lo), 32'h0);

        // R7: held level does not set again; a new edge does
        repeat (3) cyc();
        expect_reg("R7 held level", 4'd6, 32'h0);
        lo_flags[1*4 + 2] = 1'b0;
        cyc();
        lo_flags[1*4 + 2] = 1'b1;
        cyc();
        expect_reg("R7 new edge", 4'd6, 32'h0000_0002);

        // R3: queue 9 inverted empty flag (reg 1 bits 7:4)
        wr(4'd1, 32'h0000_0040);
        wr(4'd4, 32'h0000_0202);
        lo_flags[9*4 + 0] = 1'b1;
        cyc();
        lo_flags[9*4 + 0] = 1'b0;
        cyc();
        expect_reg("R3 inverted", 4'd6, 32'h0000_0202);
        expect_reg("R11 highest lo", 4'd8, 32'h8000_0009);

        // R4: reserved bits dropped; queue 16 field 0xF acts as 0x7
        wr(4'd2, 32'hFFFF_FFFF);
        expect_reg("R4 readback", 4'd2, 32'h7777_7777);
        wr(4'd4, 32'h0001_0202);
        lo_flags[16*4 + 3] = 1'b1;
        cyc();
        lo_flags[16*4 + 3] = 1'b0;
        cyc();
        expect_reg("R4 no effect", 4'd6, 32'h0001_0202);

        // R7: edge on a disabled queue (queue 2, empty flag)
        lo_flags[2*4 + 0] = 1'b1;
        cyc();
        cyc();
        expect_reg("R7 disabled", 4'd6, 32'h0001_0202);
        wr(4'd6, 32'hFFFF_FFFF);
        expect_reg("R8 clear all", 4'd6, 32'h0);

        // R6: high half fixed condition
        wr(4'd5, 32'h8000_0020);
        hi_avail[5] = 1'b1;
        hi_avail[7] = 1'b1;
        cyc();
        expect_reg("R6 stat hi", 4'd7, 32'h0000_0020);
        chk("R6 irq_hi", 32'(irq_hi), 32'h1);
        hi_avail[31] = 1'b1;
        cyc();
        expect_reg("R11 top hi", 4'd9, 32'h8000_001F);

        // R9: set and clear on the same bit in one cycle
        hi_avail[5] = 1'b0;
        cyc();
        hi_avail[5] = 1'b1;
        wr(4'd7, 32'h8000_0020);
        expect_reg("R9 set wins", 4'd7, 32'h0000_0020);

        // R10: pending but disabled does not drive the line
        wr(4'd5, 32'h0);
        expect_reg("R10 stat kept", 4'd7, 32'h0000_0020);
        chk("R10 masked", 32'(irq_hi), 32'h0);
        expect_reg("R11 none valid", 4'd9, 32'h0);
        wr(4'd7, 32'hFFFF_FFFF);

        // R12: unmapped address
        wr(4'd12, 32'hFFFF_FFFF);
        expect_reg("R12 unmapped", 4'd12, 32'h0);
        expect_reg("R12 en kept", 4'd4, 32'h0001_0202);

        // random traffic against the model
        for (int n = 0; n < 3000; n++) begin
            for (int k = 0; k < 3; k++) lo_flags[$urandom % 128] ^= 1'b1;
            hi_avail[$urandom % 32] ^= 1'b1;
            bus_we    = ($urandom % 4) == 0;
            bus_addr  = 4'($urandom % 12);
            bus_wdata = $urandom;
            cyc();
        end
        bus_we = 1'b0;

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule